// File: doc/BRIEF.md
# Burst Column Address Sequencer

The sequencer produces the column address for every data beat of a memory read or write burst. A controller pulses `start_i` together with a starting column, a burst-length code and an ordering mode. From the next cycle on, the block presents one column address per cycle on `col_o`. `beat_valid_o` stays high for exactly as many cycles as the burst has beats, and `last_o` marks the final beat.

The beats walk an aligned window whose size is the burst length. In sequential order the low window bits count upward from the start offset and wrap back to zero at the window edge, with no carry into the bits above. In interleaved order the low window bits of beat k are the start offset XORed with k. In both orders the column bits above the window keep their starting values. A new legal start always wins over the burst in flight, so bursts can abut with no idle cycle or cut a running burst short.

Top module: `burst_col_seq`

## Requirements
- R1: While `rst_ni` is low (asynchronous, active low), `beat_valid_o` and `last_o` are 0, and they stay 0 until a legal start arrives.
- R2: `bl_sel_i` encodes the burst length as 01 = 2 beats, 10 = 4 beats and 11 = 8 beats. A start with a legal code makes `beat_valid_o` high from the next cycle for exactly that many consecutive cycles, and beat 0 shows `start_col_i` unchanged.
- R3: With `mode_i` = 0 (sequential), the low window bits of beat k equal (start offset + k) modulo the burst length.
- R4: With `mode_i` = 1 (interleaved), the low window bits of beat k equal the start offset XOR k.
- R5: Column bits above the window (above bit 0, 1 or 2 for lengths 2, 4 or 8) equal the starting column on every beat.
- R6: `last_o` is high only on the final beat of a burst, and never while `beat_valid_o` is low.
- R7: A legal start during a running burst, including on its last beat, ends that burst, and the new burst's beat 0 appears on the next cycle with no gap.
- R8: A start with `bl_sel_i` = 00 is ignored: an idle block stays idle, and a running burst goes on unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse that loads a new burst |
| start_col_i | input | 9 | Starting column address |
| bl_sel_i | input | 2 | Burst length code (01 = 2, 10 = 4, 11 = 8, 00 = illegal) |
| mode_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| col_o | output | 9 | Column address of the current beat |
| beat_valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | The current beat is the last of its burst |

## Verification
A new start and the end of a burst in flight can fall in the same cycle. This happens when a legal start arrives on the last beat (the back-to-back case) or on an earlier beat (the abort case), and also when an illegal start arrives mid-burst. In every case the bench checks the cycle after the start: beat 0 of the new burst must appear with no idle gap, or, for the illegal code, the old burst must carry on with its next expected beat. The checker compares valid, last and the upper column bits across these boundaries cycle by cycle.

// File: rtl/burst_col_seq_pkg.sv
package burst_col_seq_pkg;
  localparam int COL_W     = 9;
  localparam int BLSEL_W   = 2;
  localparam int WIN_W_MAX = 3;
  localparam int CNT_W     = WIN_W_MAX;

  typedef enum logic [BLSEL_W-1:0] {
    BL_NONE = 2'b00,
    BL_2    = 2'b01,
    BL_4    = 2'b10,
    BL_8    = 2'b11
  } bl_sel_e;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } order_e;
endpackage

// File: rtl/burst_cfg_dec.sv
module burst_cfg_dec
  import burst_col_seq_pkg::*;
#(
  parameter int BL_W  = BLSEL_W,
  parameter int WIN_W = WIN_W_MAX
) (
  input  logic [BL_W-1:0]  bl_sel_i,
  output logic             legal_o,
  output logic [WIN_W-1:0] mask_o,
  output logic [WIN_W-1:0] last_idx_o
);
  // code value equals log2(burst length)
  localparam int CODE_MAX = WIN_W;

  assign legal_o = (bl_sel_i != '0) && (int'(bl_sel_i) <= CODE_MAX);

  for (genvar i = 0; i < WIN_W; i++) begin : g_mask
    assign mask_o[i] = (int'(bl_sel_i) > i);
  end

  // beats - 1 == window mask
  assign last_idx_o = mask_o;
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] last_idx_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             active_o,
  output logic             last_o
);
  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_idx_q;

  assign last_o   = active_q && (cnt_q == last_idx_q);
  assign active_o = active_q;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      cnt_q      <= '0;
      last_idx_q <= '0;
    end else if (load_i) begin
      active_q   <= 1'b1;
      cnt_q      <= '0;
      last_idx_q <= last_idx_i;
    end else if (active_q) begin
      if (last_o) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int COL_W = 9,
  parameter int WIN_W = 3
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [WIN_W-1:0] mask_i,
  input  logic             ilv_i,
  input  logic [WIN_W-1:0] cnt_i,
  output logic [COL_W-1:0] col_o
);
  logic [WIN_W-1:0] seq_low;
  logic [WIN_W-1:0] ilv_low;
  logic [WIN_W-1:0] win_low;

  // sum truncated to window width; masking below drops the carry
  assign seq_low = base_i[WIN_W-1:0] + cnt_i;
  assign ilv_low = base_i[WIN_W-1:0] ^ cnt_i;
  assign win_low = ilv_i ? ilv_low : seq_low;

  for (genvar i = 0; i < WIN_W; i++) begin : g_low
    assign col_o[i] = mask_i[i] ? win_low[i] : base_i[i];
  end

  assign col_o[COL_W-1:WIN_W] = base_i[COL_W-1:WIN_W];
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_col_seq_pkg::*;
#(
  parameter int COL_BITS = COL_W,
  parameter int BL_BITS  = BLSEL_W,
  parameter int WIN_BITS = WIN_W_MAX
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [COL_BITS-1:0] start_col_i,
  input  logic [BL_BITS-1:0]  bl_sel_i,
  input  logic                mode_i,
  output logic [COL_BITS-1:0] col_o,
  output logic                beat_valid_o,
  output logic                last_o
);
  logic                legal;
  logic                load;
  logic [WIN_BITS-1:0] mask_d;
  logic [WIN_BITS-1:0] last_idx_d;
  logic [WIN_BITS-1:0] cnt;
  logic [COL_BITS-1:0] base_q;
  logic [WIN_BITS-1:0] mask_q;
  logic                ilv_q;

  burst_cfg_dec #(
    .BL_W (BL_BITS),
    .WIN_W(WIN_BITS)
  ) u_dec (
    .bl_sel_i  (bl_sel_i),
    .legal_o   (legal),
    .mask_o    (mask_d),
    .last_idx_o(last_idx_d)
  );

  assign load = start_i && legal;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      mask_q <= '0;
      ilv_q  <= 1'b0;
    end else if (load) begin
      base_q <= start_col_i;
      mask_q <= mask_d;
      ilv_q  <= (mode_i == ORD_ILV);
    end
  end

  burst_beat_ctr #(
    .CNT_W(WIN_BITS)
  ) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .last_idx_i(last_idx_d),
    .cnt_o     (cnt),
    .active_o  (beat_valid_o),
    .last_o    (last_o)
  );

  burst_addr_gen #(
    .COL_W(COL_BITS),
    .WIN_W(WIN_BITS)
  ) u_gen (
    .base_i(base_q),
    .mask_i(mask_q),
    .ilv_i (ilv_q),
    .cnt_i (cnt),
    .col_o (col_o)
  );
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_BITS = 9,
  parameter int BL_BITS  = 2,
  parameter int WIN_BITS = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic [COL_BITS-1:0] start_col_i,
  input logic [BL_BITS-1:0]  bl_sel_i,
  input logic [COL_BITS-1:0] col_o,
  input logic                beat_valid_o,
  input logic                last_o
);
  logic legal_start;
  assign legal_start = start_i && (bl_sel_i != '0) && (int'(bl_sel_i) <= WIN_BITS);

  p_first_beat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal_start |=> beat_valid_o && (col_o == $past(start_col_i)));

  p_last_ends_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && last_o && !legal_start) |=> !beat_valid_o);

  p_last_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> beat_valid_o);

  p_high_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && $past(beat_valid_o) && !$past(legal_start))
      |-> (col_o[COL_BITS-1:WIN_BITS] == $past(col_o[COL_BITS-1:WIN_BITS])));

  p_idle_ignore_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!beat_valid_o && start_i && !legal_start) |=> !beat_valid_o);

  p_run_ignore_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && !last_o && start_i && !legal_start) |=> beat_valid_o);
endmodule

bind burst_col_seq burst_col_seq_chk #(
  .COL_BITS(COL_BITS),
  .BL_BITS (BL_BITS),
  .WIN_BITS(WIN_BITS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .bl_sel_i    (bl_sel_i),
  .col_o       (col_o),
  .beat_valid_o(beat_valid_o),
  .last_o      (last_o)
);

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int NVEC       = 8;

  // {start_col[8:0], bl_sel[1:0], mode}
  localparam logic [11:0] VEC [NVEC] = '{
    {9'h000, 2'b11, 1'b0},
    {9'h0A5, 2'b11, 1'b0},
    {9'h0A5, 2'b11, 1'b1},
    {9'h1FF, 2'b01, 1'b0},
    {9'h1FF, 2'b01, 1'b1},
    {9'h136, 2'b10, 1'b0},
    {9'h136, 2'b10, 1'b1},
    {9'h0F3, 2'b10, 1'b0}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [8:0] start_col_i = '0;
  logic [1:0] bl_sel_i = '0;
  logic       mode_i = 1'b0;
  logic [8:0] col_o;
  logic       beat_valid_o;
  logic       last_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  burst_col_seq u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .bl_sel_i    (bl_sel_i),
    .mode_i      (mode_i),
    .col_o       (col_o),
    .beat_valid_o(beat_valid_o),
    .last_o      (last_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog: act=%0d cycles exp<=%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] exp_col(logic [8:0] s, logic [1:0] bl, logic m, int k);
    int blen = 1 << bl;
    int msk  = blen - 1;
    int low  = m ? ((int'(s) ^ k) & msk) : ((int'(s) + k) % blen);
    return 9'((int'(s) & ~msk) | low);
  endfunction

  task automatic start_pulse(logic [8:0] s, logic [1:0] bl, logic m);
    start_i = 1'b1; start_col_i = s; bl_sel_i = bl; mode_i = m;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  // check beats k0..k1-1, one per cycle; optionally the idle cycle after
  task automatic check_beats(logic [8:0] s, logic [1:0] bl, logic m, int k0, int k1, bit end_chk);
    int blen = 1 << bl;
    int msk  = blen - 1;
    for (int k = k0; k < k1; k++) begin
      logic [8:0] e = exp_col(s, bl, m, k);
      check("R2 valid", int'(beat_valid_o), 1);
      if (m) check("R4 interleave low bits", int'(col_o) & msk, int'(e) & msk);
      else   check("R3 sequential low bits", int'(col_o) & msk, int'(e) & msk);
      check("R5 upper bits", int'(col_o) & ~msk, int'(s) & ~msk);
      check("R6 last flag", int'(last_o), int'(k == blen - 1));
      @(negedge clk_i);
    end
    if (end_chk) begin
      check("R2 valid drops after burst", int'(beat_valid_o), 0);
      check("R6 last low when idle", int'(last_o), 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD/4);
    check("R1 reset valid", int'(beat_valid_o), 0);
    check("R1 reset last", int'(last_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 idle after reset", int'(beat_valid_o), 0);

    for (int v = 0; v < NVEC; v++) begin
      logic [8:0] s  = VEC[v][11:3];
      logic [1:0] bl = VEC[v][2:1];
      logic       m  = VEC[v][0];
      start_pulse(s, bl, m);
      check("R2 beat0 is start column", int'(col_o), int'(s));
      check_beats(s, bl, m, 0, 1 << bl, 1'b1);
    end

    // R8: illegal code while idle
    start_pulse(9'h055, 2'b00, 1'b0);
    check("R8 idle ignore valid", int'(beat_valid_o), 0);
    check("R8 idle ignore last", int'(last_o), 0);

    // R8: illegal code mid-burst, burst continues
    start_pulse(9'h040, 2'b11, 1'b1);
    check_beats(9'h040, 2'b11, 1'b1, 0, 2, 1'b0);
    start_pulse(9'h1AA, 2'b00, 1'b0);
    check_beats(9'h040, 2'b11, 1'b1, 3, 8, 1'b1);

    // R7: abort at beat 3
    start_pulse(9'h010, 2'b11, 1'b0);
    check_beats(9'h010, 2'b11, 1'b0, 0, 3, 1'b0);
    start_pulse(9'h1F5, 2'b10, 1'b1);
    check("R7 abort new beat0", int'(col_o), 'h1F5);
    check("R7 abort valid no gap", int'(beat_valid_o), 1);
    check_beats(9'h1F5, 2'b10, 1'b1, 0, 4, 1'b1);

    // R7: back-to-back on last beat
    start_pulse(9'h08E, 2'b01, 1'b0);
    check_beats(9'h08E, 2'b01, 1'b0, 0, 1, 1'b0);
    check("R7 old last beat", int'(last_o), 1);
    start_pulse(9'h123, 2'b11, 1'b0);
    check("R7 back-to-back valid", int'(beat_valid_o), 1);
    check_beats(9'h123, 2'b11, 1'b0, 0, 8, 1'b1);

    // R1: async reset mid-burst
    start_pulse(9'h0C0, 2'b11, 1'b1);
    check_beats(9'h0C0, 2'b11, 1'b1, 0, 2, 1'b0);
    rst_ni = 1'b0;
    #1;
    check("R1 async reset valid", int'(beat_valid_o), 0);
    check("R1 async reset last", int'(last_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 idle after release", int'(beat_valid_o), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule